// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It reads two table entries from memory in turn. A requester presents an address together with the base of the top-level table. The walker then reads a directory entry and, when that entry is valid, a leaf entry that names the physical frame. It answers with a one-cycle completion pulse. With that pulse it gives either the translated address and the leaf's dirty flag, or a page fault that records the level where the walk stopped.

The virtual address is split 10/10/12. Bits 31:22 index the directory, bits 21:12 index the leaf table, and bits 11:0 are the byte offset within a 4 KB page. The offset passes through without change. Every table entry is 32 bits wide. Bit 0 is the valid flag, bit 1 is the dirty flag, and bits 31:12 hold a 20-bit frame number. In a directory entry that frame number points to the next table; in a leaf entry it is the physical frame. Each table access is one 32-bit read through a simple port. The walker holds the request and the address until the memory returns one response beat. Only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `fault` are 0 and `res_paddr` is 0.
- R2: A request is taken when `req_valid` is 1 and `busy` is 0. `busy` is 1 from the next cycle until the cycle after `done`. A `req_valid` seen while `busy` is 1 is ignored: it starts no walk and does not change the result.
- R3: The first read goes to the table base with its low 12 bits forced to zero, plus 4 times the virtual address bits 31:22. Every read address is 4-byte aligned.
- R4: When the directory entry has bit 0 set, the second read goes to that entry's bits 31:12 followed by 12 zero bits, plus 4 times the virtual address bits 21:12.
- R5: When the leaf entry has bit 0 set, the walk ends with `fault` = 0. `res_paddr` is the leaf's bits 31:12 joined with virtual address bits 11:0, and `res_dirty` is the leaf's bit 1.
- R6: When the directory entry has bit 0 clear, the walk ends after that single read. It reports `fault` = 1, `fault_level` = 0, `res_paddr` = 0 and `res_dirty` = 0.
- R7: When the leaf entry has bit 0 clear, the walk ends after two reads. It reports `fault` = 1, `fault_level` = 1, `res_paddr` = 0 and `res_dirty` = 0.
- R8: `done` is high for exactly one cycle per walk, and `busy` is still 1 in that cycle. The result outputs are valid in that cycle and hold until the next walk ends.
- R9: `mem_req` is 1 only while a read is outstanding. `mem_addr` stays steady from the cycle `mem_req` rises until the cycle in which `mem_rvalid` is 1. `mem_rvalid` is looked at only while `mem_req` is 1.
- R10: Reset in the middle of a walk drops it. `busy` and `mem_req` go to 0, and no read or completion of that walk follows after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | Base of the top-level table, sampled when a request is taken |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Table read outstanding |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read response beat |
| mem_rdata | input | 32 | Entry returned by memory |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended on an invalid entry |
| fault_level | output | 1 | 0: directory entry invalid, 1: leaf entry invalid |
| res_paddr | output | 32 | Translated physical address |
| res_dirty | output | 1 | Dirty flag of the leaf entry |

## Verification
The assertions take for granted that memory returns exactly one `mem_rvalid` beat for each outstanding read, and never drives a beat while `mem_req` is low. They also assume the table base and the entries returned put tables on 4 KB boundaries. The bench's memory model answers only while it sees `mem_req` high, after a chosen delay of zero to six cycles. It drops its beat on the half cycle after the walker has taken it, and it clears itself on reset. So a response never appears without a pending read, even when reset lands in the middle of a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W       = 32;
  localparam int PA_W       = 32;
  localparam int OFF_W      = 12;
  localparam int DIR_W      = 10;
  localparam int LEAF_W     = VA_W - OFF_W - DIR_W;
  localparam int PTE_W      = 32;
  localparam int FRAME_W    = PA_W - OFF_W;
  localparam int SLOT_SHIFT = 2;
  localparam int V_BIT      = 0;
  localparam int D_BIT      = 1;

  typedef enum logic [1:0] {WS_IDLE, WS_DIR, WS_LEAF, WS_DONE} wstate_e;

  typedef logic [VA_W-1:0]  vaddr_t;
  typedef logic [PA_W-1:0]  paddr_t;
  typedef logic [PTE_W-1:0] pte_t;

  function automatic logic [DIR_W-1:0] dir_idx(vaddr_t va);
    return va[VA_W-1 -: DIR_W];
  endfunction

  function automatic logic [LEAF_W-1:0] leaf_idx(vaddr_t va);
    return va[OFF_W +: LEAF_W];
  endfunction

  function automatic paddr_t page_align(paddr_t a);
    return {a[PA_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  function automatic paddr_t slot_addr(paddr_t base, paddr_t idx);
    return page_align(base) + (idx << SLOT_SHIFT);
  endfunction

  function automatic paddr_t next_table(pte_t pte);
    return {pte[PTE_W-1 -: FRAME_W], {OFF_W{1'b0}}};
  endfunction

  function automatic paddr_t join_pa(pte_t pte, vaddr_t va);
    return {pte[PTE_W-1 -: FRAME_W], va[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    mem_rvalid,
  input  logic    pte_ok,
  output wstate_e state,
  output logic    busy,
  output logic    mem_req,
  output logic    done,
  output logic    ev_accept,
  output logic    ev_dir_ok,
  output logic    ev_dir_fault,
  output logic    ev_leaf_ok,
  output logic    ev_leaf_fault
);
  wstate_e state_d;

  assign busy    = (state != WS_IDLE);
  assign mem_req = (state == WS_DIR) || (state == WS_LEAF);
  assign done    = (state == WS_DONE);

  assign ev_accept     = (state == WS_IDLE) && req_valid;
  assign ev_dir_ok     = (state == WS_DIR)  && mem_rvalid &&  pte_ok;
  assign ev_dir_fault  = (state == WS_DIR)  && mem_rvalid && !pte_ok;
  assign ev_leaf_ok    = (state == WS_LEAF) && mem_rvalid &&  pte_ok;
  assign ev_leaf_fault = (state == WS_LEAF) && mem_rvalid && !pte_ok;

  always_comb begin
    state_d = state;
    case (state)
      WS_IDLE: if (ev_accept) state_d = WS_DIR;
      WS_DIR: begin
        if (ev_dir_ok)         state_d = WS_LEAF;
        else if (ev_dir_fault) state_d = WS_DONE;
      end
      WS_LEAF: if (mem_rvalid) state_d = WS_DONE;
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= WS_IDLE;
    else        state <= state_d;
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (busy && mem_req));

  // R2
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_LEAF && !mem_rvalid) |=> (state == WS_LEAF));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R9
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (busy && !done));

  // R6
  dir_fault_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dir_fault |=> (done && !mem_req));
endmodule

// File: rtl/ptw_addr.sv
module ptw_addr
  import ptw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  wstate_e state,
  input  logic    ev_accept,
  input  logic    ev_dir_ok,
  input  logic    mem_req,
  input  logic    mem_rvalid,
  input  vaddr_t  req_vaddr,
  input  paddr_t  tbl_base,
  input  pte_t    mem_rdata,
  output vaddr_t  va_q,
  output paddr_t  mem_addr
);
  paddr_t base_q;
  paddr_t dir_slot;
  paddr_t leaf_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      base_q <= '0;
    end else if (ev_accept) begin
      va_q   <= req_vaddr;
      base_q <= page_align(tbl_base);
    end else if (ev_dir_ok) begin
      base_q <= next_table(mem_rdata);
    end
  end

  assign dir_slot  = slot_addr(base_q, paddr_t'(dir_idx(va_q)));
  assign leaf_slot = slot_addr(base_q, paddr_t'(leaf_idx(va_q)));
  assign mem_addr  = !mem_req ? '0 : (state == WS_LEAF) ? leaf_slot : dir_slot;

  logic unused_addr_bits;
  assign unused_addr_bits = ^{tbl_base[OFF_W-1:0], mem_rdata[OFF_W-1:0]};

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> $stable(mem_addr));

  // R3
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[SLOT_SHIFT-1:0] == '0));
endmodule

// File: rtl/ptw_result.sv
module ptw_result
  import ptw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev_leaf_ok,
  input  logic   ev_dir_fault,
  input  logic   ev_leaf_fault,
  input  logic   done,
  input  pte_t   mem_rdata,
  input  vaddr_t va_q,
  output logic   fault,
  output logic   fault_level,
  output paddr_t res_paddr,
  output logic   res_dirty
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault       <= 1'b0;
      fault_level <= 1'b0;
      res_paddr   <= '0;
      res_dirty   <= 1'b0;
    end else if (ev_leaf_ok) begin
      fault       <= 1'b0;
      fault_level <= 1'b0;
      res_paddr   <= join_pa(mem_rdata, va_q);
      res_dirty   <= mem_rdata[D_BIT];
    end else if (ev_dir_fault || ev_leaf_fault) begin
      fault       <= 1'b1;
      fault_level <= ev_leaf_fault;
      res_paddr   <= '0;
      res_dirty   <= 1'b0;
    end
  end

  // R5
  leaf_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_leaf_ok |=> (!fault && res_paddr[OFF_W-1:0] == $past(va_q[OFF_W-1:0])));

  // R7
  fault_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (res_paddr == '0 && !res_dirty));

  // R6
  dir_fault_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dir_fault |=> (fault && !fault_level));

  // R7
  leaf_fault_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_leaf_fault |=> (fault && fault_level));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [PA_W-1:0]   tbl_base,
  output logic              busy,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_rvalid,
  input  logic [PTE_W-1:0]  mem_rdata,
  output logic              done,
  output logic              fault,
  output logic              fault_level,
  output logic [PA_W-1:0]   res_paddr,
  output logic              res_dirty
);
  wstate_e state;
  vaddr_t  va_q;
  logic    ev_accept, ev_dir_ok, ev_dir_fault, ev_leaf_ok, ev_leaf_fault;
  logic    pte_ok;

  assign pte_ok = mem_rdata[V_BIT];

  ptw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mem_rvalid(mem_rvalid),
    .pte_ok(pte_ok), .state(state), .busy(busy), .mem_req(mem_req), .done(done),
    .ev_accept(ev_accept), .ev_dir_ok(ev_dir_ok), .ev_dir_fault(ev_dir_fault),
    .ev_leaf_ok(ev_leaf_ok), .ev_leaf_fault(ev_leaf_fault)
  );

  ptw_addr u_addr (
    .clk(clk), .rst_n(rst_n), .state(state), .ev_accept(ev_accept),
    .ev_dir_ok(ev_dir_ok), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
    .req_vaddr(req_vaddr), .tbl_base(tbl_base), .mem_rdata(mem_rdata),
    .va_q(va_q), .mem_addr(mem_addr)
  );

  ptw_result u_result (
    .clk(clk), .rst_n(rst_n), .ev_leaf_ok(ev_leaf_ok), .ev_dir_fault(ev_dir_fault),
    .ev_leaf_fault(ev_leaf_fault), .done(done), .mem_rdata(mem_rdata), .va_q(va_q),
    .fault(fault), .fault_level(fault_level), .res_paddr(res_paddr),
    .res_dirty(res_dirty)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !mem_req && !done));
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] tbl_base = '0;
  logic        busy, mem_req, done, fault, fault_level, res_dirty;
  logic [31:0] mem_addr, res_paddr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] tab_a [8];
  logic [31:0] tab_d [8];
  int          tab_n = 0;
  int          lat = 0;
  int          lat_cnt = 0;
  int          rd_cnt = 0;
  logic [31:0] rd_addr [4];

  always #10 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .tbl_base(tbl_base), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done), .fault(fault),
    .fault_level(fault_level), .res_paddr(res_paddr), .res_dirty(res_dirty)
  );

  function automatic logic [31:0] lookup(logic [31:0] a);
    for (int i = 0; i < 8; i++)
      if (i < tab_n && tab_a[i] == a) return tab_d[i];
    return 32'h0;
  endfunction

  // memory model: answers at the falling edge, beat lasts one cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      lat_cnt    <= 0;
    end else if (mem_rvalid) begin
      mem_rvalid <= 1'b0;
    end else if (mem_req) begin
      if (lat_cnt >= lat) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= lookup(mem_addr);
        if (rd_cnt < 4) rd_addr[rd_cnt] <= mem_addr;
        rd_cnt  <= rd_cnt + 1;
        lat_cnt <= 0;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected under 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clear_tab();
    tab_n = 0;
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    tab_a[tab_n] = a;
    tab_d[tab_n] = d;
    tab_n = tab_n + 1;
  endtask

  function automatic logic [31:0] exp_first(logic [31:0] base, logic [31:0] va);
    return (base & 32'hFFFF_F000) + ((va >> 22) * 4);
  endfunction

  function automatic logic [31:0] exp_second(logic [31:0] pte, logic [31:0] va);
    return (pte & 32'hFFFF_F000) + (((va >> 12) & 32'h3FF) * 4);
  endfunction

  task automatic issue(input logic [31:0] base, input logic [31:0] va);
    @(negedge clk);
    rd_cnt    = 0;
    tbl_base  = base;
    req_vaddr = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 busy after accept", {31'b0, busy}, 32'd1);
  endtask

  task automatic run_walk(input logic [31:0] base, input logic [31:0] va, input int l,
                          input bit intrude, input logic [31:0] other_va);
    logic [31:0] a1, p1, a2, p2;
    int waited;
    lat = l;
    a1 = exp_first(base, va);
    p1 = lookup(a1);
    a2 = exp_second(p1, va);
    p2 = lookup(a2);
    issue(base, va);
    if (intrude) begin
      req_vaddr = other_va;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      req_vaddr = 32'h0;
    end
    waited = 0;
    while (!done && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    check("R8 done seen", {31'b0, done}, 32'd1);
    check("R8 busy during done", {31'b0, busy}, 32'd1);
    check("R3 first read address", rd_addr[0], a1);
    if (!p1[0]) begin
      check("R6 single read", rd_cnt, 32'd1);
      check("R6 fault", {31'b0, fault}, 32'd1);
      check("R6 fault level 0", {31'b0, fault_level}, 32'd0);
      check("R6 paddr zero", res_paddr, 32'h0);
    end else begin
      check("R4 second read address", rd_addr[1], a2);
      check("R4 two reads", rd_cnt, 32'd2);
      if (!p2[0]) begin
        check("R7 fault", {31'b0, fault}, 32'd1);
        check("R7 fault level 1", {31'b0, fault_level}, 32'd1);
        check("R7 paddr zero", res_paddr, 32'h0);
        check("R7 dirty zero", {31'b0, res_dirty}, 32'd0);
      end else begin
        check("R5 no fault", {31'b0, fault}, 32'd0);
        check("R5 paddr", res_paddr, (p2 & 32'hFFFF_F000) | (va & 32'hFFF));
        check("R5 dirty", {31'b0, res_dirty}, {31'b0, p2[1]});
      end
    end
    @(negedge clk);
    check("R8 done one cycle", {31'b0, done}, 32'd0);
    check("R8 idle after done", {31'b0, busy}, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 mem_req", {31'b0, mem_req}, 32'd0);
    check("R1 fault", {31'b0, fault}, 32'd0);
    check("R1 paddr", res_paddr, 32'h0);
  endtask

  task automatic t_hits();
    clear_tab();
    put(exp_first(32'h0010_0000, 32'h1234_5678), 32'h00AB_C001);
    put(exp_second(32'h00AB_C001, 32'h1234_5678), 32'h7F00_E003);
    run_walk(32'h0010_0000, 32'h1234_5678, 2, 1'b0, 32'h0);
    clear_tab();
    put(exp_first(32'h0020_0ABC, 32'hC0DE_F00D), 32'h0003_3001);
    put(exp_second(32'h0003_3001, 32'hC0DE_F00D), 32'h1111_1001);
    run_walk(32'h0020_0ABC, 32'hC0DE_F00D, 0, 1'b0, 32'h0);
  endtask

  task automatic t_faults();
    clear_tab();
    put(exp_first(32'h0040_0000, 32'h8000_1234), 32'h0055_5002);
    run_walk(32'h0040_0000, 32'h8000_1234, 1, 1'b0, 32'h0);
    clear_tab();
    put(exp_first(32'h0040_0000, 32'h0040_2ABC), 32'h0066_6001);
    put(exp_second(32'h0066_6001, 32'h0040_2ABC), 32'hFFFF_F002);
    run_walk(32'h0040_0000, 32'h0040_2ABC, 3, 1'b0, 32'h0);
  endtask

  task automatic t_corners();
    clear_tab();
    put(exp_first(32'h0008_0000, 32'hFFFF_FFFF), 32'h0009_0001);
    put(exp_second(32'h0009_0001, 32'hFFFF_FFFF), 32'hABCD_E001);
    run_walk(32'h0008_0000, 32'hFFFF_FFFF, 1, 1'b0, 32'h0);
    clear_tab();
    put(exp_first(32'h0008_0000, 32'h0000_0000), 32'h000A_0003);
    put(exp_second(32'h000A_0003, 32'h0000_0000), 32'h0000_1003);
    run_walk(32'h0008_0000, 32'h0000_0000, 0, 1'b0, 32'h0);
  endtask

  task automatic t_ignore_busy();
    clear_tab();
    put(exp_first(32'h0030_0000, 32'h2468_ACE0), 32'h0044_4001);
    put(exp_second(32'h0044_4001, 32'h2468_ACE0), 32'h0BAD_0001);
    put(exp_first(32'h0030_0000, 32'h9000_0123), 32'h0077_7001);
    run_walk(32'h0030_0000, 32'h2468_ACE0, 3, 1'b1, 32'h9000_0123);
    @(negedge clk);
    check("R2 no walk from ignored request", {31'b0, busy}, 32'd0);
    check("R2 no extra read", rd_cnt, 32'd2);
  endtask

  task automatic t_mid_reset();
    clear_tab();
    put(exp_first(32'h0050_0000, 32'h0123_4567), 32'h0088_8001);
    put(exp_second(32'h0088_8001, 32'h0123_4567), 32'h0CAF_E001);
    lat = 6;
    issue(32'h0050_0000, 32'h0123_4567);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 busy in reset", {31'b0, busy}, 32'd0);
    check("R10 mem_req in reset", {31'b0, mem_req}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (busy || mem_req || done) begin
        check("R10 walk dropped", {29'b0, busy, mem_req, done}, 32'd0);
        break;
      end
    end
    check("R10 no read after reset", rd_cnt, 32'd0);
    run_walk(32'h0050_0000, 32'h0123_4567, 1, 1'b0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hits();
    t_faults();
    t_corners();
    t_ignore_busy();
    t_mid_reset();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule